// File: doc/BRIEF.md
# Multi-Chain Calibration Retention Table

This block keeps radio calibration results for a parameterised number of receive chains and can play them back to the radio on request. Every chain owns a bank of six 28-bit entries. The three lowest entries hold the DC-offset DAC settings (loop, low and high). Entry 3 holds the filter setting, entry 4 the receive gain and entry 5 the peak-detector offset. Software never addresses an entry directly. It loads a per-chain data register, then writes a per-chain command register with an entry index, a direction bit and a start bit. It then polls the start bit until the hardware clears it. A read access works the other way round and leaves the entry in the data register.

A global control register holds an enable, a six-bit replay mask with one bit per entry index, and a force bit. When software sets force while the table is enabled, a sequencer walks every chain and every index. It starts at chain 0 and goes up the indices inside a chain. For each index whose mask bit is set, it drives the chain number, index and stored value onto a replay bus with a one-cycle strobe. The force bit reads back as 1 until the walk ends.

Top module: `calkeep_table`

## Requirements
- R1: After reset every entry, every command and data register and the control register read 0, and the replay strobe is low.
- R2: A command write with start (bit 4) and write-select (bit 3) at 1 and index in bits 2:0 copies the chain's data register (bits 27:0) into the addressed entry of that chain only.
- R3: The start bit reads 1 for exactly 4 cycles after the command write edge and reads 0 from the 5th cycle on.
- R4: A command write with start at 1 and write-select at 0 loads the addressed entry into the chain's data register when start clears.
- R5: An index of 6 or 7 changes no entry on a write access and loads 0 into the data register on a read access.
- R6: While a chain's start bit is 1, writes to that chain's command and data registers are ignored.
- R7: An access on one chain leaves the entries and data registers of the other chains unchanged.
- R8: A control write (address 0) with enable (bit 0) and force (bit 7) at 1 replays the entries whose bit in the mask (bits 6:1, bit 1 = index 0) is set. Chain 0 goes first, indices ascend, and each item carries chain, index and stored data with a one-cycle strobe.
- R9: Force reads 1 from the start edge until 6 × N_CHAINS cycles after it, then reads 0.
- R10: A force write with enable at 0 starts no replay, and force reads 0 right after that write.
- R11: Control writes during a replay are ignored: mask, enable and the replay sequence are unchanged.
- R12: Register map: address 0 is control, address 1+2c is the command register of chain c, and address 2+2c is the data register of chain c. Any other address reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| reg_wr_i | input | 1 | Register write strobe |
| reg_waddr_i | input | AW = clog2(2·N_CHAINS+1) | Register write address |
| reg_wdata_i | input | 32 | Register write data |
| reg_raddr_i | input | AW | Register read address |
| reg_rdata_o | output | 32 | Register read data (combinational) |
| rpl_vld_o | output | 1 | Replay item strobe |
| rpl_chain_o | output | CHW = max(1, clog2(N_CHAINS)) | Chain of the replay item |
| rpl_idx_o | output | 3 | Entry index of the replay item |
| rpl_data_o | output | 28 | Stored value of the replay item |

## Verification
A stuck or skipped access counter shows up as a start bit that clears one cycle early or late. The bench checks that bit on every cycle of the 4-cycle window. A wrongly decoded index or chain, or a bank write that reaches the wrong row, shows up on the next read-back of that entry as a wrong value in the data register. A sequencer that skips a slot, replays an unmasked entry or reorders chains puts a mismatching item on the replay bus within one cycle. A miscounted walk length appears as a force bit that clears on the wrong cycle.

// File: rtl/calkeep_pkg.sv
package calkeep_pkg;
  localparam int ENTRIES   = 6;
  localparam int IDX_W     = 3;
  localparam int DATA_W    = 28;
  localparam int REG_W     = 32;
  localparam int ACC_LAT   = 4;
  localparam int MASK_LO   = 1;
  localparam int CTL_EN    = 0;
  localparam int CTL_FORCE = 7;

  typedef logic [DATA_W-1:0]  entry_t;
  typedef logic [ENTRIES-1:0] mask_t;

  typedef struct packed {
    logic             go;
    logic             wsel;
    logic [IDX_W-1:0] addr;
  } cmd_t;

  localparam int CMD_W = $bits(cmd_t);
endpackage

// File: rtl/calkeep_bank.sv
module calkeep_bank
  import calkeep_pkg::*;
#(
  parameter  int LAT = ACC_LAT,
  localparam int CW  = $clog2(LAT + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_wr_i,
  input  logic             data_wr_i,
  input  entry_t           wdata_i,
  output cmd_t             cmd_o,
  output entry_t           data_o,
  output logic             busy_o,
  input  logic [IDX_W-1:0] peek_idx_i,
  output entry_t           peek_data_o
);

  cmd_t          cmd_q, cmd_d;
  entry_t        data_q, data_d;
  logic [CW-1:0] cnt_q, cnt_d;
  entry_t        tbl_q [ENTRIES];
  logic [ENTRIES-1:0] row_we;
  logic          finish;
  logic          addr_ok;
  entry_t        sel_entry;

  assign finish  = cmd_q.go && (cnt_q == '0);
  assign addr_ok = (cmd_q.addr < IDX_W'(ENTRIES));

  always_comb begin
    sel_entry = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (cmd_q.addr == IDX_W'(i)) sel_entry = tbl_q[i];
    end
  end

  always_comb begin
    peek_data_o = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (peek_idx_i == IDX_W'(i)) peek_data_o = tbl_q[i];
    end
  end

  // next state of the access handshake
  always_comb begin
    cmd_d  = cmd_q;
    data_d = data_q;
    cnt_d  = cnt_q;
    if (cmd_q.go) begin
      if (cnt_q == '0) begin
        cmd_d.go = 1'b0;
        if (!cmd_q.wsel) data_d = addr_ok ? sel_entry : '0;
      end else begin
        cnt_d = cnt_q - CW'(1);
      end
    end else begin
      if (cmd_wr_i) begin
        cmd_d = cmd_t'(wdata_i[CMD_W-1:0]);
        cnt_d = CW'(LAT - 1);
      end
      if (data_wr_i) data_d = wdata_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q  <= '0;
      data_q <= '0;
      cnt_q  <= '0;
    end else begin
      cmd_q  <= cmd_d;
      data_q <= data_d;
      cnt_q  <= cnt_d;
    end
  end

  for (genvar i = 0; i < ENTRIES; i++) begin : g_row
    assign row_we[i] = finish && cmd_q.wsel && (cmd_q.addr == IDX_W'(i));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         tbl_q[i] <= '0;
      else if (row_we[i]) tbl_q[i] <= data_q;
    end
  end

  assign cmd_o  = cmd_q;
  assign data_o = data_q;
  assign busy_o = cmd_q.go;

endmodule

// File: rtl/calkeep_replay.sv
module calkeep_replay
  import calkeep_pkg::*;
#(
  parameter  int NCH = 3,
  localparam int CHW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  mask_t            mask_i,
  output logic             active_o,
  output logic [CHW-1:0]   sel_ch_o,
  output logic [IDX_W-1:0] sel_idx_o,
  input  entry_t           sel_data_i,
  output logic             vld_o,
  output logic [CHW-1:0]   out_ch_o,
  output logic [IDX_W-1:0] out_idx_o,
  output entry_t           out_data_o
);

  localparam int MX = 2 ** IDX_W;

  logic             active_q, active_d;
  logic [CHW-1:0]   ch_q, ch_d;
  logic [IDX_W-1:0] idx_q, idx_d;
  logic             vld_q, vld_d;
  logic [CHW-1:0]   och_q;
  logic [IDX_W-1:0] oidx_q;
  entry_t           odat_q;
  logic [MX-1:0]    mask_ext;

  assign mask_ext = {{(MX - ENTRIES){1'b0}}, mask_i};

  always_comb begin
    active_d = active_q;
    ch_d     = ch_q;
    idx_d    = idx_q;
    vld_d    = 1'b0;
    if (!active_q) begin
      if (start_i) begin
        active_d = 1'b1;
        ch_d     = '0;
        idx_d    = '0;
      end
    end else begin
      vld_d = mask_ext[idx_q];
      if (idx_q == IDX_W'(ENTRIES - 1)) begin
        idx_d = '0;
        if (ch_q == CHW'(NCH - 1)) active_d = 1'b0;
        else                       ch_d     = ch_q + CHW'(1);
      end else begin
        idx_d = idx_q + IDX_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      ch_q     <= '0;
      idx_q    <= '0;
      vld_q    <= 1'b0;
    end else begin
      active_q <= active_d;
      ch_q     <= ch_d;
      idx_q    <= idx_d;
      vld_q    <= vld_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      och_q  <= '0;
      oidx_q <= '0;
      odat_q <= '0;
    end else if (active_q) begin
      och_q  <= ch_q;
      oidx_q <= idx_q;
      odat_q <= sel_data_i;
    end
  end

  assign active_o   = active_q;
  assign sel_ch_o   = ch_q;
  assign sel_idx_o  = idx_q;
  assign vld_o      = vld_q;
  assign out_ch_o   = och_q;
  assign out_idx_o  = oidx_q;
  assign out_data_o = odat_q;

endmodule

// File: rtl/calkeep_table.sv
module calkeep_table
  import calkeep_pkg::*;
#(
  parameter  int N_CHAINS   = 3,
  parameter  int ACCESS_LAT = ACC_LAT,
  localparam int AW         = $clog2(2 * N_CHAINS + 1),
  localparam int CHW        = (N_CHAINS > 1) ? $clog2(N_CHAINS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr_i,
  input  logic [AW-1:0]     reg_waddr_i,
  input  logic [REG_W-1:0]  reg_wdata_i,
  input  logic [AW-1:0]     reg_raddr_i,
  output logic [REG_W-1:0]  reg_rdata_o,
  output logic              rpl_vld_o,
  output logic [CHW-1:0]    rpl_chain_o,
  output logic [IDX_W-1:0]  rpl_idx_o,
  output logic [DATA_W-1:0] rpl_data_o
);

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rs_q;
  logic       srst_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign srst_n = rs_q[1];

  // control register
  logic   en_q, en_d;
  mask_t  mask_q, mask_d;
  logic   ctl_wr;
  logic   rp_start;
  logic   rp_active;

  assign ctl_wr   = reg_wr_i && (reg_waddr_i == '0) && !rp_active;
  assign rp_start = ctl_wr && reg_wdata_i[CTL_FORCE] && reg_wdata_i[CTL_EN];

  always_comb begin
    en_d   = en_q;
    mask_d = mask_q;
    if (ctl_wr) begin
      en_d   = reg_wdata_i[CTL_EN];
      mask_d = reg_wdata_i[MASK_LO +: ENTRIES];
    end
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      en_q   <= 1'b0;
      mask_q <= '0;
    end else begin
      en_q   <= en_d;
      mask_q <= mask_d;
    end
  end

  // banks
  cmd_t                 bk_cmd  [N_CHAINS];
  entry_t               bk_data [N_CHAINS];
  entry_t               bk_peek [N_CHAINS];
  logic [N_CHAINS-1:0]  bk_busy;
  logic [N_CHAINS-1:0]  cmd_wr;
  logic [N_CHAINS-1:0]  data_wr;
  logic [CHW-1:0]       sel_ch;
  logic [IDX_W-1:0]     sel_idx;
  entry_t               sel_data;

  for (genvar c = 0; c < N_CHAINS; c++) begin : g_bank
    assign cmd_wr[c]  = reg_wr_i && (reg_waddr_i == AW'(1 + 2 * c));
    assign data_wr[c] = reg_wr_i && (reg_waddr_i == AW'(2 + 2 * c));

    calkeep_bank #(.LAT(ACCESS_LAT)) u_bank (
      .clk         (clk),
      .rst_n       (srst_n),
      .cmd_wr_i    (cmd_wr[c]),
      .data_wr_i   (data_wr[c]),
      .wdata_i     (reg_wdata_i[DATA_W-1:0]),
      .cmd_o       (bk_cmd[c]),
      .data_o      (bk_data[c]),
      .busy_o      (bk_busy[c]),
      .peek_idx_i  (sel_idx),
      .peek_data_o (bk_peek[c])
    );
  end

  always_comb begin
    sel_data = '0;
    for (int c = 0; c < N_CHAINS; c++) begin
      if (sel_ch == CHW'(c)) sel_data = bk_peek[c];
    end
  end

  calkeep_replay #(.NCH(N_CHAINS)) u_replay (
    .clk        (clk),
    .rst_n      (srst_n),
    .start_i    (rp_start),
    .mask_i     (mask_q),
    .active_o   (rp_active),
    .sel_ch_o   (sel_ch),
    .sel_idx_o  (sel_idx),
    .sel_data_i (sel_data),
    .vld_o      (rpl_vld_o),
    .out_ch_o   (rpl_chain_o),
    .out_idx_o  (rpl_idx_o),
    .out_data_o (rpl_data_o)
  );

  // register read mux
  always_comb begin
    reg_rdata_o = '0;
    if (reg_raddr_i == '0)
      reg_rdata_o = {{(REG_W - 8){1'b0}}, rp_active, mask_q, en_q};
    for (int c = 0; c < N_CHAINS; c++) begin
      if (reg_raddr_i == AW'(1 + 2 * c))
        reg_rdata_o = {{(REG_W - CMD_W){1'b0}}, bk_cmd[c]};
      if (reg_raddr_i == AW'(2 + 2 * c))
        reg_rdata_o = {{(REG_W - DATA_W){1'b0}}, bk_data[c]};
    end
  end

  logic unused_wdata;
  assign unused_wdata = ^reg_wdata_i[REG_W-1:DATA_W];

endmodule

// File: rtl/calkeep_table_chk.sv
module calkeep_table_chk
  import calkeep_pkg::*;
#(
  parameter  int N_CHAINS = 3,
  localparam int CHW      = (N_CHAINS > 1) ? $clog2(N_CHAINS) : 1
) (
  input logic                clk,
  input logic                rst_n,
  input logic                vld,
  input logic [CHW-1:0]      ch,
  input logic [IDX_W-1:0]    idx,
  input logic                active,
  input mask_t               mask,
  input logic [N_CHAINS-1:0] busy
);

  logic [7:0] mask_ext;
  int         key;
  int         last_key;
  logic       have_last;

  assign mask_ext = {2'b00, mask};
  assign key      = int'(ch) * ENTRIES + int'(idx);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      have_last <= 1'b0;
      last_key  <= 0;
    end else if (!active) begin
      have_last <= 1'b0;
    end else if (vld) begin
      have_last <= 1'b1;
      last_key  <= key;
    end
  end

  // R8: replayed items stay inside the table and follow the mask
  a_r8_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    vld |-> (int'(idx) < ENTRIES) && (int'(ch) < N_CHAINS));

  a_r8_masked_only: assert property (@(posedge clk) disable iff (!rst_n)
    vld |-> mask_ext[idx]);

  a_r8_ascending: assert property (@(posedge clk) disable iff (!rst_n)
    (vld && have_last) |-> (key > last_key));

  // R9: a strobe only follows a running walk
  a_r9_strobe_in_walk: assert property (@(posedge clk) disable iff (!rst_n)
    vld |-> $past(active));

  // R11: the mask is frozen while the walk runs
  a_r11_mask_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (active && $past(active)) |-> $stable(mask));

  // R3: an access never ends in the cycle after it starts
  for (genvar c = 0; c < N_CHAINS; c++) begin : g_busy
    a_r3_go_holds: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy[c]) |=> busy[c]);
  end

endmodule

bind calkeep_table calkeep_table_chk #(.N_CHAINS(N_CHAINS)) u_chk (
  .clk    (clk),
  .rst_n  (srst_n),
  .vld    (rpl_vld_o),
  .ch     (rpl_chain_o),
  .idx    (rpl_idx_o),
  .active (rp_active),
  .mask   (mask_q),
  .busy   (bk_busy)
);

// File: tb/calkeep_table_test.sv
module calkeep_table_test;
  localparam int NCH = 3;
  localparam int AW  = 3;
  localparam int CHW = 2;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              reg_wr;
  logic [AW-1:0]     reg_waddr;
  logic [31:0]       reg_wdata;
  logic [AW-1:0]     reg_raddr;
  logic [31:0]       reg_rdata;
  logic              rpl_vld;
  logic [CHW-1:0]    rpl_chain;
  logic [2:0]        rpl_idx;
  logic [27:0]       rpl_data;

  always #5 clk = ~clk;

  calkeep_table #(.N_CHAINS(NCH)) uut (
    .clk(clk), .rst_n(rst_n),
    .reg_wr_i(reg_wr), .reg_waddr_i(reg_waddr), .reg_wdata_i(reg_wdata),
    .reg_raddr_i(reg_raddr), .reg_rdata_o(reg_rdata),
    .rpl_vld_o(rpl_vld), .rpl_chain_o(rpl_chain), .rpl_idx_o(rpl_idx),
    .rpl_data_o(rpl_data)
  );

  typedef struct { int ch; int idx; logic [27:0] d; } item_t;
  item_t       expq[$];
  logic [27:0] model [NCH][6];
  int n_vec = 0;
  int n_bad = 0;
  int n_rx  = 0;
  bit done  = 0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // monitor: scoreboard pop on every replay strobe
  always @(negedge clk) begin
    if (rst_n && rpl_vld) begin
      n_rx++;
      n_vec++;
      if (expq.size() == 0) begin
        n_bad++;
        $display("FAIL R8/R10: actual unexpected item ch%0d idx%0d expected none", rpl_chain, rpl_idx);
      end else begin
        item_t e;
        e = expq.pop_front();
        if (int'(rpl_chain) != e.ch || int'(rpl_idx) != e.idx || rpl_data !== e.d) begin
          n_bad++;
          $display("FAIL R8: actual ch%0d idx%0d %h expected ch%0d idx%0d %h",
                   rpl_chain, rpl_idx, rpl_data, e.ch, e.idx, e.d);
        end
      end
    end
  end

  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_waddr = AW'(a); reg_wdata = d;
    @(posedge clk); #1;
    reg_wr = 1'b0;
  endtask

  task automatic rd(input int a, output logic [31:0] d);
    @(negedge clk);
    reg_raddr = AW'(a);
    #1 d = reg_rdata;
  endtask

  function automatic logic [31:0] cmdw(input int idx, input bit wsel);
    return {27'd0, 1'b1, wsel, 3'(idx)};
  endfunction

  task automatic wait_done(input int ch, input string tag);
    logic [31:0] r;
    r = 32'h10;
    for (int t = 0; t < 40 && r[4]; t++) rd(1 + 2 * ch, r);
    chk({tag, " start clears"}, {31'd0, r[4]}, 32'd0);
  endtask

  task automatic tbl_wr(input int ch, input int idx, input logic [27:0] d);
    wr(2 + 2 * ch, {4'h0, d});
    wr(1 + 2 * ch, cmdw(idx, 1'b1));
    wait_done(ch, "R2");
  endtask

  task automatic tbl_rd(input int ch, input int idx, output logic [27:0] q);
    logic [31:0] r;
    wr(1 + 2 * ch, cmdw(idx, 1'b0));
    wait_done(ch, "R4");
    rd(2 + 2 * ch, r);
    q = r[27:0];
  endtask

  task automatic push_exp(input logic [5:0] m);
    for (int c = 0; c < NCH; c++)
      for (int i = 0; i < 6; i++)
        if (m[i]) expq.push_back('{c, i, model[c][i]});
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_vec++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] r;
    logic [27:0] q;
    int rx0;
    reg_wr = 0; reg_waddr = '0; reg_wdata = '0; reg_raddr = '0;
    rst_n = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    repeat (3) @(posedge clk);

    // R1 reset state
    for (int a = 0; a < 7; a++) begin
      rd(a, r);
      chk($sformatf("R1 reg %0d", a), r, 32'd0);
    end
    tbl_rd(0, 5, q); chk("R1 entry c0 i5", {4'h0, q}, 32'd0);
    tbl_rd(2, 0, q); chk("R1 entry c2 i0", {4'h0, q}, 32'd0);
    chk("R1 no strobe", {31'd0, rpl_vld}, 32'd0);

    // R12 unmapped address
    rd(7, r); chk("R12 unmapped read", r, 32'd0);

    // R3 start bit window
    wr(2, 32'h0ABCDEF);
    reg_raddr = AW'(1);
    wr(1, cmdw(1, 1'b1));
    for (int k = 0; k < 4; k++) begin
      chk($sformatf("R3 busy cycle %0d", k), {31'd0, reg_rdata[4]}, 32'd1);
      @(posedge clk); #1;
    end
    chk("R3 cleared", {31'd0, reg_rdata[4]}, 32'd0);
    chk("R12 command readback", reg_rdata, 32'h0000_0009);
    model[0][1] = 28'h0ABCDEF;

    // R2 / R4 / R7 fill all banks with distinct values
    for (int c = 0; c < NCH; c++)
      for (int i = 0; i < 6; i++) begin
        model[c][i] = 28'(((c + 1) * 32'h0111_1111) ^ (i * 32'h0013_579B));
        tbl_wr(c, i, model[c][i]);
      end
    for (int c = 0; c < NCH; c++)
      for (int i = 0; i < 6; i++) begin
        tbl_rd(c, i, q);
        chk($sformatf("R2 R4 R7 c%0d i%0d", c, i), {4'h0, q}, {4'h0, model[c][i]});
      end

    // R5 out-of-range index
    tbl_wr(0, 6, 28'hFFFFFFF);
    tbl_wr(0, 7, 28'h5555555);
    for (int i = 0; i < 6; i++) begin
      tbl_rd(0, i, q);
      chk($sformatf("R5 untouched i%0d", i), {4'h0, q}, {4'h0, model[0][i]});
    end
    wr(2, 32'h0777_7777);
    tbl_rd(0, 6, q); chk("R5 read idx6 zero", {4'h0, q}, 32'd0);

    // R6 writes during busy ignored
    wr(4, {4'h0, 28'h1234567});
    wr(3, cmdw(2, 1'b1));
    wr(4, 32'h0FEDCBA);
    wr(3, cmdw(4, 1'b0));
    wait_done(1, "R6");
    rd(3, r); chk("R6 command kept", r[2:0], 32'd2);
    rd(4, r); chk("R6 data kept", r, 32'h0123_4567);
    model[1][2] = 28'h1234567;
    tbl_rd(1, 4, q); chk("R6 entry4 untouched", {4'h0, q}, {4'h0, model[1][4]});
    tbl_rd(1, 2, q); chk("R6 entry2 written", {4'h0, q}, {4'h0, model[1][2]});
    tbl_rd(0, 2, q); chk("R7 chain0 entry2", {4'h0, q}, {4'h0, model[0][2]});

    // R8 / R9 replay with a sparse mask
    push_exp(6'b101101);
    rx0 = n_rx;
    reg_raddr = '0;
    wr(0, {24'd0, 1'b1, 6'b101101, 1'b1});
    chk("R9 force set", {31'd0, reg_rdata[7]}, 32'd1);
    repeat (17) begin @(posedge clk); #1; end
    chk("R9 force still set", {31'd0, reg_rdata[7]}, 32'd1);
    @(posedge clk); #1;
    chk("R9 force cleared", {31'd0, reg_rdata[7]}, 32'd0);
    repeat (3) @(posedge clk);
    chk("R8 item count", n_rx - rx0, 32'(4 * NCH));
    chk("R8 queue drained", expq.size(), 32'd0);

    // R8 full mask
    push_exp(6'b111111);
    wr(0, {24'd0, 1'b1, 6'b111111, 1'b1});
    repeat (25) @(posedge clk);
    chk("R8 full queue drained", expq.size(), 32'd0);

    // R10 disabled force
    rx0 = n_rx;
    reg_raddr = '0;
    wr(0, {24'd0, 1'b1, 6'b111111, 1'b0});
    chk("R10 force clears at once", {31'd0, reg_rdata[7]}, 32'd0);
    repeat (25) @(posedge clk);
    chk("R10 no items", n_rx - rx0, 32'd0);

    // R11 control write during replay ignored
    rx0 = n_rx;
    push_exp(6'b000011);
    wr(0, {24'd0, 1'b1, 6'b000011, 1'b1});
    repeat (3) @(posedge clk);
    wr(0, {24'd0, 1'b1, 6'b110000, 1'b1});
    rd(0, r); chk("R11 mask kept", r[6:0], {25'd0, 6'b000011, 1'b1});
    repeat (30) @(posedge clk);
    chk("R11 one walk only", n_rx - rx0, 32'(2 * NCH));
    chk("R11 queue drained", expq.size(), 32'd0);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule